// File: doc/BRIEF.md
# Double-Data-Rate Half-Character Transmit Serializer

This block takes one lane of line-coded 10-bit characters. They arrive over a 5-bit parallel port that carries a new half-character on each edge of a character clock. The block joins each pair of halves into a full character and sends the character out one bit per clock, most significant bit first. Ten bits go out in every character period.

The model uses a single clock that runs at the bit rate. The two edges of the character clock are given as strobes that last one cycle:
- `rise_stb` stands for the rising edge.
- `fall_stb` stands for the falling edge.

In normal use each strobe fires once in every ten cycles, and the two are about five cycles apart.

The half captured at a rising strobe is always the leading half of the character. A full character waits in a one-deep holding slot until the output frame boundary. The serial frame is free-running, has ten cycles, and is aligned to reset. When no character is waiting, a fixed idle pattern is sent instead. A loopback port shows each newly assembled character, so the receive path can be tested without the serial line.

Top module: `ddr_half_serializer`

## Requirements
- R1: The 5-bit value present with `rise_stb` becomes character bits [9:5], and the value present with the next `fall_stb` becomes bits [4:0].
- R2: `ser_out` changes once per clock and sends each 10-bit frame bit 9 first. Frames follow each other with no gap and no repeated bit, starting from the cycle reset is released.
- R3: A character is sent only after both of its halves are captured. It is loaded at the next frame boundary, which falls every ten cycles from reset. A character completed at edge 10f+7 (f counted in frames from reset release) goes out as frame f+1.
- R4: When no complete character is waiting at a frame boundary, the next frame is the idle pattern `IDLE` (default 10'b0011111010, sent bit 9 first).
- R5: A `fall_stb` with no captured first half since the last completion is ignored. No character is built, the loopback valid stays low, and the next frame is idle.
- R6: Several `rise_stb` pulses before one `fall_stb` leave only the latest first half in use.
- R7: A character completed on the same edge as a frame reload is not in that reload. The reload sends idle, and the character goes out in the frame after it.
- R8: On the cycle after a completing `fall_stb`, `lpbk_valid` is high for one cycle and `lpbk_char` holds the assembled character.
- R9: Synchronous reset starts a fresh idle frame, drops any captured first half and any waiting character, and clears `lpbk_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| rise_stb | input | 1 | Character-clock rising-edge strobe (first half) |
| fall_stb | input | 1 | Character-clock falling-edge strobe (second half) |
| half_in | input | 5 | Half-character data |
| ser_out | output | 1 | Serial output, MSB first |
| lpbk_char | output | 10 | Last assembled character |
| lpbk_valid | output | 1 | One-cycle pulse when `lpbk_char` is updated |

## Verification
The hardest case to reach from the ports is a character that completes on the very edge where the frame reloads (R7). In that case the holding slot is written and read in the same cycle. The bench reaches it by moving the strobe phase of one character period so that `fall_stb` lands on the tenth bit of the frame. It then checks that an idle frame comes out before the character. It also reaches the orphan second half (R5) by leaving out the rising strobe for one period. It reaches the overwritten first half (R6) by sending two rising strobes before one falling strobe.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
    localparam int HALF_W = 5;
    localparam int CHAR_W = 2 * HALF_W;
    localparam int CNT_W  = $clog2(CHAR_W);

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [CHAR_W-1:0] char_t;

    // Default filler frame: a comma-bearing control character
    localparam char_t IDLE_CHAR = char_t'(10'b0011111010);

    typedef struct packed {
        logic  valid;
        char_t data;
    } slot_t;

    // Leading half occupies the upper bits
    function automatic char_t join_halves(half_t lead, half_t trail);
        return {lead, trail};
    endfunction
endpackage

// File: rtl/dsr_half_capture.sv
module dsr_half_capture
    import dsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rise_stb,
    input  logic  fall_stb,
    input  half_t half_in,
    input  logic  take,
    output slot_t pend,
    output slot_t lpbk
);
    half_t lead_q;
    logic  lead_have;
    slot_t pend_q;
    slot_t lpbk_q;
    logic  complete;
    char_t joined;

    assign complete = fall_stb && lead_have;
    assign joined   = join_halves(lead_q, half_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            lead_q    <= '0;
            lead_have <= 1'b0;
            pend_q    <= '0;
            lpbk_q    <= '0;
        end else begin
            lpbk_q.valid <= complete;
            if (complete) begin
                lpbk_q.data <= joined;
            end
            if (rise_stb) begin
                lead_q    <= half_in;
                lead_have <= 1'b1;
            end else if (complete) begin
                lead_have <= 1'b0;
            end
            if (complete) begin
                pend_q.valid <= 1'b1;
                pend_q.data  <= joined;
            end else if (take) begin
                pend_q.valid <= 1'b0;
            end
        end
    end

    assign pend = pend_q;
    assign lpbk = lpbk_q;

    // R1: halves land in their fixed positions
    a_r1_half_order: assert property (@(posedge clk) disable iff (rst)
        (fall_stb && lead_have) |=>
            (lpbk.data[CHAR_W-1 -: HALF_W] == $past(lead_q)) &&
            (lpbk.data[HALF_W-1:0] == $past(half_in)));

    // R5: orphan second half produces nothing
    a_r5_orphan_fall: assert property (@(posedge clk) disable iff (rst)
        (fall_stb && !lead_have) |=> !lpbk.valid);

    // R6: a later rising strobe replaces the held first half
    a_r6_lead_replace: assert property (@(posedge clk) disable iff (rst)
        rise_stb |=> (lead_have && lead_q == $past(half_in)));

    // R3: a waiting character stays put until taken
    a_r3_pend_hold: assert property (@(posedge clk) disable iff (rst)
        (pend.valid && !take && !fall_stb) |=> (pend.valid && $stable(pend.data)));
endmodule

// File: rtl/dsr_frame_shifter.sv
module dsr_frame_shifter
    import dsr_pkg::*;
#(
    parameter char_t IDLE = IDLE_CHAR
) (
    input  logic  clk,
    input  logic  rst,
    input  slot_t pend,
    output logic  take,
    output logic  ser_out
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_W - 1);

    logic [CNT_W-1:0] bit_cnt;
    char_t            shreg;

    assign take    = (bit_cnt == LAST);
    assign ser_out = shreg[CHAR_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            shreg   <= IDLE;
        end else if (take) begin
            bit_cnt <= '0;
            shreg   <= pend.valid ? pend.data : IDLE;
        end else begin
            bit_cnt <= bit_cnt + 1'b1;
            shreg   <= {shreg[CHAR_W-2:0], 1'b0};
        end
    end

    // R2: inside a frame each cycle exposes the next lower bit
    a_r2_shift_step: assert property (@(posedge clk) disable iff (rst)
        (bit_cnt != LAST) |=> (ser_out == $past(shreg[CHAR_W-2])));

    // R2: frame position advances by one each cycle
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (bit_cnt != LAST) |=> (bit_cnt == $past(bit_cnt) + 1'b1));

    // R3: a waiting character is what the reload picks up
    a_r3_load_pending: assert property (@(posedge clk) disable iff (rst)
        (take && pend.valid) |=> (shreg == $past(pend.data)));

    // R4: empty slot at the boundary yields the filler frame
    a_r4_idle_fill: assert property (@(posedge clk) disable iff (rst)
        (take && !pend.valid) |=> (shreg == IDLE));
endmodule

// File: rtl/ddr_half_serializer.sv
module ddr_half_serializer
    import dsr_pkg::*;
#(
    parameter char_t IDLE = IDLE_CHAR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic [HALF_W-1:0] half_in,
    output logic              ser_out,
    output logic [CHAR_W-1:0] lpbk_char,
    output logic              lpbk_valid
);
    slot_t pend;
    slot_t lpbk;
    logic  take;

    dsr_half_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .half_in  (half_in),
        .take     (take),
        .pend     (pend),
        .lpbk     (lpbk)
    );

    dsr_frame_shifter #(.IDLE(IDLE)) u_shifter (
        .clk     (clk),
        .rst     (rst),
        .pend    (pend),
        .take    (take),
        .ser_out (ser_out)
    );

    assign lpbk_char  = lpbk.data;
    assign lpbk_valid = lpbk.valid;

    // R8: the loopback pulse follows a completing falling strobe
    a_r8_lpbk_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(lpbk_valid) |-> $past(fall_stb));

    // R9: reset leaves nothing waiting and no loopback pulse
    a_r9_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!lpbk_valid && !pend.valid));
endmodule

// File: tb/ddr_half_serializer_test.sv
module ddr_half_serializer_test;
    localparam int NSLOT = 14;
    localparam int NEDGE = NSLOT * 10;
    localparam logic [9:0] IDLE_P = 10'b0011111010;
    localparam logic [9:0] VEC [8] = '{10'h17C, 10'h283, 10'h3FF, 10'h000,
                                       10'h155, 10'h2AA, 10'h0F0, 10'h30F};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rise_stb = 1'b0;
    logic       fall_stb = 1'b0;
    logic [4:0] half_in = '0;
    logic       ser_out;
    logic [9:0] lpbk_char;
    logic       lpbk_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    ddr_half_serializer uut (
        .clk        (clk),
        .rst        (rst),
        .rise_stb   (rise_stb),
        .fall_stb   (fall_stb),
        .half_in    (half_in),
        .ser_out    (ser_out),
        .lpbk_char  (lpbk_char),
        .lpbk_valid (lpbk_valid)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    int         r1ph [NSLOT];
    int         r2ph [NSLOT];
    int         fph  [NSLOT];
    logic [9:0] chr  [NSLOT];
    logic [9:0] expf [NSLOT];
    string      reqf [NSLOT];
    logic       stream [NEDGE];

    initial begin
        bit         have_lead;
        bit         prev_fall;
        bit         exp_v;
        logic [9:0] exp_c;
        logic [9:0] got;

        // stimulus table walk: eight ordinary characters
        for (int f = 0; f < NSLOT; f++) begin
            r1ph[f] = -1; r2ph[f] = -1; fph[f] = -1; chr[f] = '0;
        end
        for (int f = 0; f < 8; f++) begin
            r1ph[f] = 2; fph[f] = 7; chr[f] = VEC[f];
        end
        fph[9]  = 7; chr[9] = 10'h2AA;                      // R5 orphan
        r1ph[10] = 1; r2ph[10] = 4; fph[10] = 7; chr[10] = 10'h1C7; // R6
        r1ph[11] = 5; fph[11] = 9; chr[11] = 10'h0F3;       // R7 reload collision

        expf[0] = IDLE_P; reqf[0] = "R9";
        for (int f = 0; f < 8; f++) begin
            expf[f+1] = VEC[f]; reqf[f+1] = (f == 0) ? "R3" : "R1";
        end
        expf[9]  = IDLE_P;   reqf[9]  = "R4";
        expf[10] = IDLE_P;   reqf[10] = "R5";
        expf[11] = 10'h1C7;  reqf[11] = "R6";
        expf[12] = IDLE_P;   reqf[12] = "R7";
        expf[13] = 10'h0F3;  reqf[13] = "R7";

        repeat (3) @(posedge clk);
        have_lead = 1'b0;
        prev_fall = 1'b0;
        exp_v = 1'b0;
        exp_c = '0;
        for (int e = 0; e < NEDGE; e++) begin
            @(negedge clk);
            if (e == 0) begin
                chk(lpbk_valid === 1'b0, "R9", "lpbk_valid after reset",
                    {9'b0, lpbk_valid}, 10'h000);
            end
            rst = 1'b0;
            stream[e] = ser_out;
            if (prev_fall) begin
                chk(lpbk_valid === exp_v, exp_v ? "R8" : "R5", "lpbk_valid",
                    {9'b0, lpbk_valid}, {9'b0, exp_v});
                if (exp_v) chk(lpbk_char === exp_c, "R8", "lpbk_char", lpbk_char, exp_c);
            end
            begin
                int f;
                int ph;
                f = e / 10;
                ph = e % 10;
                rise_stb = 1'b0;
                fall_stb = 1'b0;
                prev_fall = 1'b0;
                if (ph == r1ph[f]) begin
                    rise_stb = 1'b1;
                    half_in = (r2ph[f] >= 0) ? 5'b10101 : chr[f][9:5];
                    have_lead = 1'b1;
                end else if (ph == r2ph[f]) begin
                    rise_stb = 1'b1;
                    half_in = chr[f][9:5];
                    have_lead = 1'b1;
                end else if (ph == fph[f]) begin
                    fall_stb = 1'b1;
                    half_in = chr[f][4:0];
                    exp_v = have_lead;
                    exp_c = chr[f];
                    have_lead = 1'b0;
                    prev_fall = 1'b1;
                end
            end
        end
        @(negedge clk);
        rise_stb = 1'b0;
        fall_stb = 1'b0;

        // R2 framing: rebuild each 10-cycle frame, MSB first
        for (int f = 0; f < NSLOT; f++) begin
            for (int b = 0; b < 10; b++) got[9-b] = stream[10*f + b];
            chk(got === expf[f], reqf[f], $sformatf("frame %0d (R2 order)", f),
                got, expf[f]);
        end

        // R9: reset drops a captured first half
        rise_stb = 1'b1;
        half_in = 5'h1F;
        @(negedge clk);
        rise_stb = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        stream[0] = ser_out;
        fall_stb = 1'b1;
        half_in = 5'h0A;
        for (int k = 1; k < 20; k++) begin
            @(negedge clk);
            fall_stb = 1'b0;
            if (k == 1) chk(lpbk_valid === 1'b0, "R9", "lpbk_valid after orphaned half",
                            {9'b0, lpbk_valid}, 10'h000);
            if (k < 10) stream[k] = ser_out;
            else stream[k] = ser_out;
        end
        for (int b = 0; b < 10; b++) got[9-b] = stream[b];
        chk(got === IDLE_P, "R9", "first frame after reset", got, IDLE_P);
        for (int b = 0; b < 10; b++) got[9-b] = stream[10 + b];
        chk(got === IDLE_P, "R9", "second frame after reset", got, IDLE_P);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule